// File: doc/BRIEF.md
# Serial Delay-Setting Command Receiver

This block takes 8-bit command words from a write-only serial port and stores them in four small settings registers. The port has three pins: an active-low frame enable, a serial clock and serial data. Three registers hold 5-bit delay codes, one for each of the red, green and blue channels. The fourth register is a test register. It holds a 4-bit signed slice-level code and a test-mode flag. The block decodes each delay code into a delay value in 2 ns units and each slice code into a signed level in millivolts.

The serial pins are not used as clocks. The block samples them with a system clock that runs at least four times faster than the serial clock. Each pin passes through a two-flop synchronizer, and the block finds the falling edges of the serial clock itself.

A word carries bits in this order: a read/write flag, then a 2-bit register address, then a 5-bit payload. Payload bits enter the addressed register one at a time as they arrive. A word that stops early therefore leaves that register partly changed.

Top module: `dly_ser_cfg`

## Requirements
- R1: After reset, all four registers read 0. All outputs are then 0 and the test mode is off.
- R2: A bit is taken from the data pin only on a falling edge of the serial clock while the frame enable is low. Serial clock edges while the enable is high change no output.
- R3: Each word is 8 bits. Bit 0 is the read/write flag. Bits 1 and 2 are the address, sent MSB first: 01 selects red, 10 selects green, 11 selects blue and 00 selects the test register. Bits 3 to 7 are the payload, sent MSB first.
- R4: Each delay output in nanoseconds equals its 5-bit code times 2, so it runs from 0 to 62.
- R5: A word whose first bit is 1 changes no register. It still uses up 8 bit positions, so the next word in the same frame decodes correctly.
- R6: Each payload bit shifts into the LSB of the addressed register, and the older contents move up one place. After k payload bits, the register holds its old value shifted left by k, with the new bits at the bottom.
- R7: After 8 bits, the next bit in the same frame is the read/write flag of a new word.
- R8: In the test register, the first four payload bits form the slice code, MSB first. The fifth payload bit is the test-mode flag, where 1 means test mode.
- R9: When the frame enable goes high, the bit position returns to the start of a word. The next frame then begins with a new read/write flag.
- R10: The slice output in millivolts is the slice code, read as a 4-bit two's-complement number, times 50. It runs from -400 (code 1000) to +350 (code 0111).
- R11: A register updates within 4 system-clock cycles of the serial clock's falling edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, at least 4x the serial clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| ser_en_n | input | 1 | Active-low frame enable |
| ser_clk | input | 1 | Serial clock; data is taken on its falling edge |
| ser_dat | input | 1 | Serial data |
| dly_r | output | 5 | Red delay code |
| dly_g | output | 5 | Green delay code |
| dly_b | output | 5 | Blue delay code |
| dly_r_ns | output | 6 | Red delay in ns |
| dly_g_ns | output | 6 | Green delay in ns |
| dly_b_ns | output | 6 | Blue delay in ns |
| slice_code | output | 4 | Two's-complement slice-level code |
| test_mode | output | 1 | Test-mode flag |
| slice_mv | output | 10 | Signed slice level in mV |

## Verification
Two events can reach the block in the same system-clock cycle: the frame enable rising and a serial clock falling edge. The bench provokes this by driving both pins in the same cycle partway through a word. The enable must win. That edge must not load a bit, and the bit count must restart. The bench judges the result by the state of the registers and by a complete word sent afterwards, which must land intact. Near-exhaustive sweeps of every delay code on every channel and every test-register payload are compared with values the bench computes arithmetically.

// File: rtl/dly_ser_cfg.sv
module dly_ser_cfg #(
  parameter int CW      = 5,
  parameter int NSW     = 6,
  parameter int MVW     = 10,
  parameter int STEP_NS = 2,
  parameter int STEP_MV = 50
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  ser_en_n,
  input  logic                  ser_clk,
  input  logic                  ser_dat,
  output logic [CW-1:0]         dly_r,
  output logic [CW-1:0]         dly_g,
  output logic [CW-1:0]         dly_b,
  output logic [NSW-1:0]        dly_r_ns,
  output logic [NSW-1:0]        dly_g_ns,
  output logic [NSW-1:0]        dly_b_ns,
  output logic [CW-2:0]         slice_code,
  output logic                  test_mode,
  output logic signed [MVW-1:0] slice_mv
);
  localparam int WLEN = 3 + CW;
  localparam int CNTW = $clog2(WLEN);

  logic [2:0] en_s, ck_s;
  logic [1:0] dt_s;
  logic [CNTW-1:0] bit_cnt;
  logic rw_q;
  logic [1:0] adr_q;
  logic [CW-1:0] cfg_q [4];
  logic fall, din;
  logic [4*CW-1:0] cfg_all;

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      en_s <= '1;
      ck_s <= '1;
      dt_s <= '0;
    end else begin
      en_s <= {en_s[1:0], ser_en_n};
      ck_s <= {ck_s[1:0], ser_clk};
      dt_s <= {dt_s[0], ser_dat};
    end

  assign fall = ck_s[2] & ~ck_s[1] & ~en_s[1];
  assign din  = dt_s[1];

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      bit_cnt <= '0;
      rw_q    <= 1'b0;
      adr_q   <= '0;
      for (int i = 0; i < 4; i++) cfg_q[i] <= '0;
    end else if (en_s[1]) begin
      bit_cnt <= '0;
    end else if (fall) begin
      bit_cnt <= (bit_cnt == CNTW'(WLEN-1)) ? '0 : bit_cnt + 1'b1;
      if (bit_cnt == 0)      rw_q     <= din;
      else if (bit_cnt == 1) adr_q[1] <= din;
      else if (bit_cnt == 2) adr_q[0] <= din;
      else if (!rw_q)        cfg_q[adr_q] <= {cfg_q[adr_q][CW-2:0], din};
    end

  assign dly_r      = cfg_q[1];
  assign dly_g      = cfg_q[2];
  assign dly_b      = cfg_q[3];
  assign dly_r_ns   = NSW'(cfg_q[1]) * NSW'(STEP_NS);
  assign dly_g_ns   = NSW'(cfg_q[2]) * NSW'(STEP_NS);
  assign dly_b_ns   = NSW'(cfg_q[3]) * NSW'(STEP_NS);
  assign slice_code = cfg_q[0][CW-1:1];
  assign test_mode  = cfg_q[0][0];

  logic signed [MVW-1:0] slice_ext;
  assign slice_ext = {{(MVW-CW+1){slice_code[CW-2]}}, slice_code};
  assign slice_mv  = slice_ext * $signed(MVW'(STEP_MV));

  assign cfg_all = {cfg_q[3], cfg_q[2], cfg_q[1], cfg_q[0]};

  p_idle_hold_r2: assert property (@(posedge clk) disable iff (!rst_n)
    !fall |=> $stable(cfg_all));
  p_read_ignored_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (fall && rw_q && bit_cnt > 2) |=> $stable(cfg_all));
  p_word_wrap_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (fall && bit_cnt == CNTW'(WLEN-1)) |=> bit_cnt == 0);
  p_bit_advance_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (fall && bit_cnt != CNTW'(WLEN-1)) |=> bit_cnt == CNTW'($past(bit_cnt) + 1'b1));
  p_frame_restart_r9: assert property (@(posedge clk) disable iff (!rst_n)
    en_s[1] |=> bit_cnt == 0);
endmodule

// File: tb/dly_ser_cfg_tb_top.sv
module dly_ser_cfg_tb_top;
  localparam int HALF = 6;
  logic clk = 0, rst_n = 0, ser_en_n = 1, ser_clk = 1, ser_dat = 0;
  logic [4:0] dly_r, dly_g, dly_b;
  logic [5:0] dly_r_ns, dly_g_ns, dly_b_ns;
  logic [3:0] slice_code;
  logic test_mode;
  logic signed [9:0] slice_mv;
  int n_chk = 0, n_fail = 0;
  int m_reg [4];
  int m_cnt = 0, m_rw = 0, m_adr = 0;

  always #2 clk = ~clk;

  dly_ser_cfg dut_i (.clk, .rst_n, .ser_en_n, .ser_clk, .ser_dat,
    .dly_r, .dly_g, .dly_b, .dly_r_ns, .dly_g_ns, .dly_b_ns,
    .slice_code, .test_mode, .slice_mv);

  task automatic chk(string req, string what, int got, int exp);
    n_chk++;
    if (got != exp) begin
      n_fail++;
      $display("FAIL %s %s: got %0d expected %0d", req, what, got, exp);
    end
  endtask

  task automatic check_all(string req);
    int sc = m_reg[0] >> 1;
    chk(req, "dly_r", int'(dly_r), m_reg[1]);
    chk(req, "dly_g", int'(dly_g), m_reg[2]);
    chk(req, "dly_b", int'(dly_b), m_reg[3]);
    chk(req, "dly_r_ns", int'(dly_r_ns), m_reg[1] * 2);
    chk(req, "dly_g_ns", int'(dly_g_ns), m_reg[2] * 2);
    chk(req, "dly_b_ns", int'(dly_b_ns), m_reg[3] * 2);
    chk(req, "slice_code", int'(slice_code), sc);
    chk(req, "test_mode", int'(test_mode), m_reg[0] & 1);
    chk(req, "slice_mv", int'(slice_mv), (sc >= 8 ? sc - 16 : sc) * 50);
  endtask

  task automatic model_bit(int b);
    if (m_cnt == 0) m_rw = b;
    else if (m_cnt == 1) m_adr = (m_adr & 1) | (b << 1);
    else if (m_cnt == 2) m_adr = (m_adr & 2) | b;
    else if (m_rw == 0) m_reg[m_adr] = ((m_reg[m_adr] << 1) | b) & 31;
    m_cnt = (m_cnt + 1) % 8;
  endtask

  task automatic sbit(logic b);
    ser_dat = b;
    repeat (HALF) @(negedge clk);
    ser_clk = 0;
    model_bit(int'(b));
    repeat (HALF) @(negedge clk);
    ser_clk = 1;
  endtask

  task automatic fbegin();
    ser_en_n = 0;
    repeat (HALF) @(negedge clk);
  endtask

  task automatic fend();
    repeat (HALF) @(negedge clk);
    ser_en_n = 1;
    m_cnt = 0;
    repeat (HALF) @(negedge clk);
  endtask

  task automatic word(logic [7:0] w);
    for (int i = 7; i >= 0; i--) sbit(w[i]);
  endtask

  task automatic summary();
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  endtask

  initial begin
    repeat (300000) @(posedge clk);
    n_chk++; n_fail++;
    $display("FAIL watchdog: got timeout expected completion");
    summary();
  end

  initial begin
    for (int i = 0; i < 4; i++) m_reg[i] = 0;
    repeat (3) @(negedge clk);
    rst_n = 1;
    repeat (3) @(negedge clk);
    check_all("R1");

    // R3 R4: every code on every delay channel
    for (int ch = 1; ch < 4; ch++)
      for (int c = 0; c < 32; c++) begin
        fbegin(); word({1'b0, 2'(ch), 5'(c)}); fend();
        check_all("R3_R4");
      end

    // R8 R10: every test-register payload
    for (int p = 0; p < 32; p++) begin
      fbegin(); word({3'b000, 5'(p)}); fend();
      check_all("R8_R10");
    end

    // R5: read word ignored, next word in same burst stays aligned
    fbegin();
    word(8'b1_01_10101);
    check_all("R5");
    word(8'b0_10_01010);
    fend();
    check_all("R5");
    chk("R5", "dly_g aligned", int'(dly_g), 10);

    // R7: three words back to back in one burst
    fbegin();
    word(8'b0_01_00111); word(8'b0_11_11000); word(8'b0_00_10011);
    fend();
    check_all("R7");

    // R6: short word leaves partial shift
    fbegin(); sbit(0); sbit(1); sbit(1); sbit(0); sbit(1); fend();
    check_all("R6");
    chk("R6", "dly_b partial", int'(dly_b), 5'b00001);
    // R9: enable raise restarts the word
    fbegin(); sbit(0); sbit(1); fend();
    fbegin(); word(8'b0_01_11110); fend();
    check_all("R9");
    chk("R9", "dly_r", int'(dly_r), 30);

    // R2: serial clock toggling with enable high
    for (int k = 0; k < 16; k++) begin
      ser_dat = k[0];
      repeat (HALF) @(negedge clk);
      ser_clk = 0;
      repeat (HALF) @(negedge clk);
      ser_clk = 1;
    end
    repeat (HALF) @(negedge clk);
    check_all("R2");

    // enable rise in the same cycle as a serial falling edge
    fbegin(); sbit(0); sbit(1); sbit(1);
    ser_dat = 1;
    repeat (HALF) @(negedge clk);
    ser_clk = 0; ser_en_n = 1; m_cnt = 0;
    repeat (HALF) @(negedge clk);
    ser_clk = 1;
    repeat (HALF) @(negedge clk);
    check_all("R9");
    fbegin(); word(8'b0_11_01101); fend();
    check_all("R9");
    chk("R9", "dly_b after collision", int'(dly_b), 13);

    // R11: latency from the final falling edge
    fbegin();
    for (int i = 7; i >= 1; i--) sbit(i == 6 || i == 5 ? 1'b1 : 1'b0);
    ser_dat = 1;
    repeat (HALF) @(negedge clk);
    ser_clk = 0;
    model_bit(1);
    repeat (4) @(negedge clk);
    check_all("R11");
    chk("R11", "dly_b latency", int'(dly_b), 1);
    ser_clk = 1;
    fend();

    summary();
  end
endmodule